// File: doc/BRIEF.md
# Dual-Channel Line Statistics Unit

This block sits behind the digitizers of a two-output linear image sensor. Odd-numbered pixels arrive on one sample stream and even-numbered pixels on the other, each sample tagged with its pixel index. The block rebuilds the line as a single stream in index order. From that stream it collects calibration statistics over a programmable window of valid pixels and ignores the shielded, dummy and unused cells on either side of the window.

The statistics are the running total, the separate totals of odd-index and even-index pixels, and the largest and smallest pixel. The extremes are tracked during the line, so the largest distance from the mean is known as soon as the mean is known and no second pass over the line is needed. Once the last window pixel has been taken, one sequential restoring divider runs five divisions. They give the mean, the odd-pixel and even-pixel means, the non-uniformity percentage and the odd/even imbalance percentage. A flag then shows that the results are valid.

A line-start pulse discards all collected state and begins a new line. Each channel may present at most one sample every two cycles. The two channels may run in step or alternate.

Top module: `line_stats_unit`

## Requirements
- R1: After reset, `done_o`, `pix_vld_o`, `mean_o`, `maxdev_o`, `nonuni_pct_o` and `imbalance_pct_o` are all zero.
- R2: A sample accepted on either channel appears on the merged output (`pix_vld_o`, `pix_idx_o`, `pix_val_o`) one cycle later. When both channels present a sample in the same cycle, the lower index comes out first and the other follows in the next cycle. Each channel carries at most one sample every two cycles.
- R3: Only merged samples whose index lies in `[FIRST_IDX, FIRST_IDX+VALID_COUNT-1]` contribute to the statistics. Samples outside the window still pass to the merged output but change no result.
- R4: `mean_o` equals floor(sum of window pixels / VALID_COUNT).
- R5: `maxdev_o` equals the larger of (window maximum − `mean_o`) and (`mean_o` − window minimum).
- R6: `nonuni_pct_o` equals floor(`maxdev_o` × 100 / `mean_o`).
- R7: A pixel is odd when bit 0 of its index is 1. The odd mean is floor(odd-window sum / number of odd window indices), and the even mean is formed the same way. `imbalance_pct_o` equals floor(|odd mean − even mean| × 100 / `mean_o`).
- R8: When `mean_o` is zero, `nonuni_pct_o` and `imbalance_pct_o` both read all ones (2^PCT_W − 1).
- R9: `done_o` rises no more than 6 × (DIV_W + 3) cycles after the last window sample is presented at the inputs. It then stays high, with all results unchanged, until the next line-start.
- R10: `line_start` clears `done_o`, the statistics and the merge buffer. A sample presented in the same cycle as `line_start` is dropped and never reaches the merged output or the statistics.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Start of a new line; clears all collected state |
| odd_vld | input | 1 | Odd-channel sample valid |
| odd_idx | input | IDX_W (14) | Odd-channel pixel index |
| odd_val | input | PIX_W (12) | Odd-channel pixel value, unsigned |
| even_vld | input | 1 | Even-channel sample valid |
| even_idx | input | IDX_W (14) | Even-channel pixel index |
| even_val | input | PIX_W (12) | Even-channel pixel value, unsigned |
| pix_vld_o | output | 1 | Merged stream valid |
| pix_idx_o | output | IDX_W (14) | Merged stream pixel index |
| pix_val_o | output | PIX_W (12) | Merged stream pixel value |
| mean_o | output | PIX_W (12) | Mean of the window pixels |
| maxdev_o | output | PIX_W (12) | Largest absolute distance from the mean |
| nonuni_pct_o | output | PCT_W (19) | Non-uniformity in percent |
| imbalance_pct_o | output | PCT_W (19) | Odd/even imbalance in percent |
| done_o | output | 1 | Results valid |

## Verification
The embedded properties check on every cycle that:
- the channel rate rule is respected while a merge slot is held;
- a simultaneous pair leaves the merger lowest index first;
- the window count never passes its limit;
- the tracked minimum never exceeds the maximum;
- each division ends with a remainder below its divisor;
- a reported mean lies between the extremes;
- the results stay frozen while the done flag is high.

The exact arithmetic of the mean, deviation and both percentages, the exclusion of cells outside the window, and the all-ones result for a zero mean can only be shown by the bench's lines of known content. The same holds for the merged ordering under in-step and alternating channel timing, and for a line-start that interrupts a partial line and drops the sample presented with it.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int PIX_W = 12;
    localparam int IDX_W = 14;
    localparam int PCT_W = PIX_W + 7;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [PIX_W-1:0] val;
    } pix_t;

    typedef enum logic [2:0] {
        FIN_IDLE,
        FIN_MEAN,
        FIN_ODD,
        FIN_EVEN,
        FIN_DEV,
        FIN_IMB,
        FIN_DONE
    } fin_e;

    function automatic logic [PIX_W-1:0] abs_diff(input logic [PIX_W-1:0] a,
                                                  input logic [PIX_W-1:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

    // number of odd indices in a window of 'count' indices beginning at 'first'
    function automatic int odd_count(input int first, input int count);
        return (first % 2 == 1) ? (count + 1) / 2 : count / 2;
    endfunction

endpackage

// File: rtl/lsu_merge.sv
module lsu_merge
    import lsu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic a_vld,
    input  pix_t a_pix,
    input  logic b_vld,
    input  pix_t b_pix,
    output logic out_vld,
    output pix_t out_pix
);

    pix_t held;
    logic held_vld;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            out_vld  <= 1'b0;
            out_pix  <= '0;
            held     <= '0;
            held_vld <= 1'b0;
        end else if (a_vld && b_vld) begin
            out_vld  <= 1'b1;
            held_vld <= 1'b1;
            if (a_pix.idx < b_pix.idx) begin
                out_pix <= a_pix;
                held    <= b_pix;
            end else begin
                out_pix <= b_pix;
                held    <= a_pix;
            end
        end else if (a_vld) begin
            out_vld <= 1'b1;
            out_pix <= a_pix;
        end else if (b_vld) begin
            out_vld <= 1'b1;
            out_pix <= b_pix;
        end else if (held_vld) begin
            out_vld  <= 1'b1;
            out_pix  <= held;
            held_vld <= 1'b0;
        end else begin
            out_vld <= 1'b0;
        end
    end

    AST_MERGE_RATE: assert property (@(posedge clk) disable iff (rst || clr)
        held_vld |-> !(a_vld || b_vld)) else $error("merge slot overrun"); // R2

    AST_MERGE_LOW_FIRST: assert property (@(posedge clk) disable iff (rst)
        (a_vld && b_vld && !clr) |=> out_vld &&
            (out_pix.idx == (($past(a_pix.idx) < $past(b_pix.idx)) ? $past(a_pix.idx) : $past(b_pix.idx))))
        else $error("merge order wrong"); // R2

endmodule

// File: rtl/lsu_accum.sv
module lsu_accum
    import lsu_pkg::*;
#(
    parameter int FIRST_IDX   = 1,
    parameter int VALID_COUNT = 7400,
    parameter int ACC_W       = PIX_W + $clog2(VALID_COUNT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             in_vld,
    input  pix_t             in_pix,
    output logic [ACC_W-1:0] sum_all,
    output logic [ACC_W-1:0] sum_odd,
    output logic [PIX_W-1:0] max_v,
    output logic [PIX_W-1:0] min_v,
    output logic             complete
);

    localparam int CNT_W = $clog2(VALID_COUNT + 1);
    localparam logic [IDX_W-1:0] WIN_LO   = IDX_W'(FIRST_IDX);
    localparam logic [IDX_W-1:0] WIN_HI   = IDX_W'(FIRST_IDX + VALID_COUNT - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(VALID_COUNT);

    logic [CNT_W-1:0] cnt;
    logic take;

    assign take = in_vld && (in_pix.idx >= WIN_LO) && (in_pix.idx <= WIN_HI) && (cnt != CNT_FULL);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt      <= '0;
            sum_all  <= '0;
            sum_odd  <= '0;
            max_v    <= '0;
            min_v    <= '0;
            complete <= 1'b0;
        end else begin
            complete <= take && (cnt == CNT_FULL - CNT_W'(1));
            if (take) begin
                cnt     <= cnt + CNT_W'(1);
                sum_all <= sum_all + ACC_W'(in_pix.val);
                if (in_pix.idx[0])
                    sum_odd <= sum_odd + ACC_W'(in_pix.val);
                if (cnt == '0 || in_pix.val > max_v)
                    max_v <= in_pix.val;
                if (cnt == '0 || in_pix.val < min_v)
                    min_v <= in_pix.val;
            end
        end
    end

    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_FULL) else $error("window count overflow"); // R3

    AST_MINMAX_ORDER: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> (min_v <= max_v)) else $error("min above max"); // R5

endmodule

// File: rtl/lsu_div.sv
module lsu_div #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo
);

    localparam int SW = $clog2(W + 1);

    logic [W:0]    rem;
    logic [W-1:0]  dvs;
    logic [SW-1:0] steps;
    logic [W:0]    shifted;
    logic          fits;

    assign shifted = {rem[W-1:0], quo[W-1]};
    assign fits    = shifted >= {1'b0, dvs};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            dvs   <= '0;
            quo   <= '0;
            steps <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                rem   <= '0;
                quo   <= num;
                dvs   <= den;
                steps <= SW'(W);
                busy  <= 1'b1;
            end else if (busy) begin
                rem   <= fits ? (shifted - {1'b0, dvs}) : shifted;
                quo   <= {quo[W-2:0], fits};
                steps <= steps - SW'(1);
                if (steps == SW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_DIV_REMAINDER: assert property (@(posedge clk) disable iff (rst)
        done |-> ((dvs == '0) || (rem < {1'b0, dvs}))) else $error("remainder not below divisor"); // R4

endmodule

// File: rtl/lsu_final.sv
module lsu_final
    import lsu_pkg::*;
#(
    parameter int FIRST_IDX   = 1,
    parameter int VALID_COUNT = 7400,
    parameter int ACC_W       = 25,
    parameter int DIV_W       = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             complete,
    input  logic [ACC_W-1:0] sum_all,
    input  logic [ACC_W-1:0] sum_odd,
    input  logic [PIX_W-1:0] max_v,
    input  logic [PIX_W-1:0] min_v,
    output logic             div_start,
    output logic [DIV_W-1:0] div_num,
    output logic [DIV_W-1:0] div_den,
    input  logic             div_busy,
    input  logic             div_done,
    input  logic [DIV_W-1:0] div_quo,
    output logic [PIX_W-1:0] mean_o,
    output logic [PIX_W-1:0] dev_o,
    output logic [PCT_W-1:0] nonuni_o,
    output logic [PCT_W-1:0] imb_o,
    output logic             done_o
);

    localparam int N_ODD  = odd_count(FIRST_IDX, VALID_COUNT);
    localparam int N_EVEN = VALID_COUNT - N_ODD;

    fin_e st;
    logic issued;
    logic in_div;
    logic [PIX_W-1:0] odd_m, even_m, dev_w, imb_diff;
    logic [ACC_W-1:0] sum_even;
    logic unused_hi;

    assign sum_even = sum_all - sum_odd;
    assign dev_w    = ((max_v - mean_o) > (mean_o - min_v)) ? (max_v - mean_o) : (mean_o - min_v);
    assign imb_diff = abs_diff(odd_m, even_m);
    assign in_div   = (st == FIN_MEAN) || (st == FIN_ODD) || (st == FIN_EVEN) ||
                      (st == FIN_DEV) || (st == FIN_IMB);
    assign div_start = in_div && !issued && !div_busy;
    assign dev_o     = dev_w;
    assign done_o    = (st == FIN_DONE);
    assign unused_hi = ^div_quo[DIV_W-1:PCT_W];

    always_comb begin
        div_num = '0;
        div_den = '0;
        case (st)
            FIN_MEAN: begin div_num = DIV_W'(sum_all);  div_den = DIV_W'(VALID_COUNT); end
            FIN_ODD:  begin div_num = DIV_W'(sum_odd);  div_den = DIV_W'(N_ODD);       end
            FIN_EVEN: begin div_num = DIV_W'(sum_even); div_den = DIV_W'(N_EVEN);      end
            FIN_DEV:  begin div_num = DIV_W'(dev_w) * DIV_W'(100);    div_den = DIV_W'(mean_o); end
            FIN_IMB:  begin div_num = DIV_W'(imb_diff) * DIV_W'(100); div_den = DIV_W'(mean_o); end
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st       <= FIN_IDLE;
            issued   <= 1'b0;
            mean_o   <= '0;
            odd_m    <= '0;
            even_m   <= '0;
            nonuni_o <= '0;
            imb_o    <= '0;
        end else begin
            case (st)
                FIN_IDLE: if (complete) st <= FIN_MEAN;
                FIN_DONE: ;
                default: begin
                    if (div_start) issued <= 1'b1;
                    if (div_done) begin
                        issued <= 1'b0;
                        case (st)
                            FIN_MEAN: begin mean_o   <= div_quo[PIX_W-1:0]; st <= FIN_ODD;  end
                            FIN_ODD:  begin odd_m    <= div_quo[PIX_W-1:0]; st <= FIN_EVEN; end
                            FIN_EVEN: begin even_m   <= div_quo[PIX_W-1:0]; st <= FIN_DEV;  end
                            FIN_DEV:  begin nonuni_o <= div_quo[PCT_W-1:0]; st <= FIN_IMB;  end
                            default:  begin imb_o    <= div_quo[PCT_W-1:0]; st <= FIN_DONE; end
                        endcase
                    end
                end
            endcase
        end
    end

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done_o && !clr) |=> (done_o && $stable(mean_o) && $stable(nonuni_o) && $stable(imb_o)))
        else $error("results moved while done"); // R9

    AST_MEAN_BOUNDS: assert property (@(posedge clk) disable iff (rst || clr)
        done_o |-> ((mean_o >= min_v) && (mean_o <= max_v))) else $error("mean outside extremes"); // R4

endmodule

// File: rtl/line_stats_unit.sv
module line_stats_unit
    import lsu_pkg::*;
#(
    parameter int FIRST_IDX   = 1,
    parameter int VALID_COUNT = 7400
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_start,
    input  logic             odd_vld,
    input  logic [IDX_W-1:0] odd_idx,
    input  logic [PIX_W-1:0] odd_val,
    input  logic             even_vld,
    input  logic [IDX_W-1:0] even_idx,
    input  logic [PIX_W-1:0] even_val,
    output logic             pix_vld_o,
    output logic [IDX_W-1:0] pix_idx_o,
    output logic [PIX_W-1:0] pix_val_o,
    output logic [PIX_W-1:0] mean_o,
    output logic [PIX_W-1:0] maxdev_o,
    output logic [PCT_W-1:0] nonuni_pct_o,
    output logic [PCT_W-1:0] imbalance_pct_o,
    output logic             done_o
);

    localparam int ACC_W = PIX_W + $clog2(VALID_COUNT + 1);
    localparam int DIV_W = (ACC_W > PCT_W) ? ACC_W : PCT_W;

    pix_t odd_pix, even_pix, m_pix;
    logic m_vld;
    logic [ACC_W-1:0] sum_all, sum_odd;
    logic [PIX_W-1:0] max_v, min_v;
    logic complete;
    logic div_start, div_busy, div_done;
    logic [DIV_W-1:0] div_num, div_den, div_quo;

    assign odd_pix  = {odd_idx, odd_val};
    assign even_pix = {even_idx, even_val};
    assign pix_vld_o = m_vld;
    assign pix_idx_o = m_pix.idx;
    assign pix_val_o = m_pix.val;

    lsu_merge u_merge (
        .clk(clk), .rst(rst), .clr(line_start),
        .a_vld(odd_vld), .a_pix(odd_pix),
        .b_vld(even_vld), .b_pix(even_pix),
        .out_vld(m_vld), .out_pix(m_pix)
    );

    lsu_accum #(.FIRST_IDX(FIRST_IDX), .VALID_COUNT(VALID_COUNT), .ACC_W(ACC_W)) u_accum (
        .clk(clk), .rst(rst), .clr(line_start),
        .in_vld(m_vld), .in_pix(m_pix),
        .sum_all(sum_all), .sum_odd(sum_odd),
        .max_v(max_v), .min_v(min_v), .complete(complete)
    );

    lsu_div #(.W(DIV_W)) u_div (
        .clk(clk), .rst(rst | line_start), .start(div_start),
        .num(div_num), .den(div_den),
        .busy(div_busy), .done(div_done), .quo(div_quo)
    );

    lsu_final #(.FIRST_IDX(FIRST_IDX), .VALID_COUNT(VALID_COUNT), .ACC_W(ACC_W), .DIV_W(DIV_W)) u_final (
        .clk(clk), .rst(rst), .clr(line_start), .complete(complete),
        .sum_all(sum_all), .sum_odd(sum_odd), .max_v(max_v), .min_v(min_v),
        .div_start(div_start), .div_num(div_num), .div_den(div_den),
        .div_busy(div_busy), .div_done(div_done), .div_quo(div_quo),
        .mean_o(mean_o), .dev_o(maxdev_o), .nonuni_o(nonuni_pct_o),
        .imb_o(imbalance_pct_o), .done_o(done_o)
    );

endmodule

// File: tb/test_line_stats_unit.sv
module test_line_stats_unit;
    import lsu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int FIRST      = 3;
    localparam int CNT        = 8;
    localparam int LINE_LEN   = 12;
    localparam int NLINES     = 6;
    localparam int DIV_W_TB   = PIX_W + 7;
    localparam int LAT_LIMIT  = 6 * (DIV_W_TB + 3);
    localparam int ALL_ONES   = (1 << PCT_W) - 1;
    localparam int MON_MAX    = 256;

    // stimulus: values for pixel indices 1..12; window is 3..10
    localparam int STIM [NLINES][LINE_LEN] = '{
        '{4095, 4095, 100, 100, 100, 100, 100, 100, 100, 100, 4095, 4095},
        '{7, 9, 10, 20, 30, 40, 50, 60, 70, 80, 1, 2},
        '{0, 0, 200, 100, 200, 100, 200, 100, 200, 100, 0, 0},
        '{4095, 4095, 0, 0, 0, 0, 0, 0, 0, 0, 4095, 4095},
        '{0, 0, 50, 50, 50, 4095, 50, 50, 50, 50, 0, 0},
        '{1, 2, 4095, 4095, 4095, 4095, 4095, 4095, 4095, 4095, 3, 4}
    };
    localparam int MODE [NLINES] = '{0, 1, 0, 1, 0, 1};  // 0 = in step, 1 = alternating

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_start = 1'b0;
    logic odd_vld = 1'b0, even_vld = 1'b0;
    logic [IDX_W-1:0] odd_idx = '0, even_idx = '0;
    logic [PIX_W-1:0] odd_val = '0, even_val = '0;
    logic pix_vld_o, done_o;
    logic [IDX_W-1:0] pix_idx_o;
    logic [PIX_W-1:0] pix_val_o, mean_o, maxdev_o;
    logic [PCT_W-1:0] nonuni_pct_o, imbalance_pct_o;

    int total = 0;
    int bad = 0;
    int mon_n = 0;
    int mon_idx [MON_MAX];
    int mon_val [MON_MAX];

    always #(CLK_PERIOD/2) clk = ~clk;

    line_stats_unit #(.FIRST_IDX(FIRST), .VALID_COUNT(CNT)) i_line_stats_unit (
        .clk(clk), .rst(rst), .line_start(line_start),
        .odd_vld(odd_vld), .odd_idx(odd_idx), .odd_val(odd_val),
        .even_vld(even_vld), .even_idx(even_idx), .even_val(even_val),
        .pix_vld_o(pix_vld_o), .pix_idx_o(pix_idx_o), .pix_val_o(pix_val_o),
        .mean_o(mean_o), .maxdev_o(maxdev_o), .nonuni_pct_o(nonuni_pct_o),
        .imbalance_pct_o(imbalance_pct_o), .done_o(done_o)
    );

    always @(negedge clk) begin
        if (pix_vld_o && mon_n < MON_MAX) begin
            mon_idx[mon_n] = int'(pix_idx_o);
            mon_val[mon_n] = int'(pix_val_o);
            mon_n++;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void exp_calc(input int ln, output int mean, output int dev,
                                     output int pct, output int imb);
        int s, so, se, no, ne, mx, mn, om, em, d;
        s = 0; so = 0; se = 0; no = 0; ne = 0; mx = 0; mn = 4095;
        for (int i = FIRST; i < FIRST + CNT; i++) begin
            int v;
            v = STIM[ln][i-1];
            s += v;
            if (i % 2 == 1) begin so += v; no++; end
            else begin se += v; ne++; end
            if (v > mx) mx = v;
            if (v < mn) mn = v;
        end
        mean = s / CNT;
        dev  = ((mx - mean) > (mean - mn)) ? (mx - mean) : (mean - mn);
        om = so / no;
        em = se / ne;
        d  = (om > em) ? (om - em) : (em - om);
        pct = (mean == 0) ? ALL_ONES : (dev * 100) / mean;
        imb = (mean == 0) ? ALL_ONES : (d * 100) / mean;
    endfunction

    task automatic pulse_start();
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic send_pair(input int ln, input int p, input int mode);
        int oi, ei;
        oi = 2 * p + 1;
        ei = 2 * p + 2;
        if (mode == 0) begin
            odd_vld = 1'b1;  odd_idx = IDX_W'(oi);  odd_val = PIX_W'(STIM[ln][oi-1]);
            even_vld = 1'b1; even_idx = IDX_W'(ei); even_val = PIX_W'(STIM[ln][ei-1]);
            @(negedge clk);
            odd_vld = 1'b0; even_vld = 1'b0;
            @(negedge clk);
        end else begin
            odd_vld = 1'b1; odd_idx = IDX_W'(oi); odd_val = PIX_W'(STIM[ln][oi-1]);
            @(negedge clk);
            odd_vld = 1'b0;
            even_vld = 1'b1; even_idx = IDX_W'(ei); even_val = PIX_W'(STIM[ln][ei-1]);
            @(negedge clk);
            even_vld = 1'b0;
        end
    endtask

    task automatic run_line(input int ln, input int mode, input bool_start);
        int base, errs, cyc, e_mean, e_dev, e_pct, e_imb, m_hold, p_hold;
        if (bool_start != 0) pulse_start();
        base = mon_n;
        for (int p = 0; p < LINE_LEN / 2; p++) send_pair(ln, p, mode);
        cyc = 0;
        while (!done_o && cyc < LAT_LIMIT + 10) begin
            @(negedge clk);
            cyc++;
        end
        check("R9", $sformatf("line %0d done within bound", ln), int'(cyc <= LAT_LIMIT && done_o), 1);
        errs = 0;
        for (int k = 0; k < LINE_LEN; k++) begin
            if (base + k >= MON_MAX || mon_idx[base+k] != k + 1 || mon_val[base+k] != STIM[ln][k])
                errs++;
        end
        check("R2", $sformatf("line %0d merged count", ln), mon_n - base, LINE_LEN);
        check("R2", $sformatf("line %0d merged order mismatches", ln), errs, 0);
        exp_calc(ln, e_mean, e_dev, e_pct, e_imb);
        check("R3 R4", $sformatf("line %0d mean", ln), int'(mean_o), e_mean);
        check("R5", $sformatf("line %0d max deviation", ln), int'(maxdev_o), e_dev);
        check(e_mean == 0 ? "R8" : "R6", $sformatf("line %0d non-uniformity", ln), int'(nonuni_pct_o), e_pct);
        check(e_mean == 0 ? "R8" : "R7", $sformatf("line %0d imbalance", ln), int'(imbalance_pct_o), e_imb);
        m_hold = int'(mean_o);
        p_hold = int'(nonuni_pct_o);
        repeat (5) @(negedge clk);
        check("R9", $sformatf("line %0d results held", ln),
              int'(done_o && int'(mean_o) == m_hold && int'(nonuni_pct_o) == p_hold), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", "done after reset", int'(done_o), 0);
        check("R1", "merged valid after reset", int'(pix_vld_o), 0);
        check("R1", "mean after reset", int'(mean_o), 0);
        check("R1", "nonuni after reset", int'(nonuni_pct_o), 0);
        check("R1", "imbalance after reset", int'(imbalance_pct_o), 0);

        // R2: single-sample merge latency
        odd_vld = 1'b1; odd_idx = IDX_W'(5); odd_val = PIX_W'(77);
        @(negedge clk);
        odd_vld = 1'b0;
        check("R2", "merged valid one cycle later", int'(pix_vld_o), 1);
        check("R2", "merged index one cycle later", int'(pix_idx_o), 5);
        check("R2", "merged value one cycle later", int'(pix_val_o), 77);
        @(negedge clk);
        check("R2", "merged valid drops after single sample", int'(pix_vld_o), 0);

        // table of lines
        for (int ln = 0; ln < NLINES; ln++) run_line(ln, MODE[ln], 1);

        // R10: interrupted partial line, sample during line_start dropped
        check("R10", "done before interruption", int'(done_o), 1);
        for (int p = 0; p < 3; p++) send_pair(4, p, 0);
        line_start = 1'b1;
        odd_vld = 1'b1; odd_idx = IDX_W'(3); odd_val = PIX_W'(4000);
        @(negedge clk);
        line_start = 1'b0;
        odd_vld = 1'b0;
        check("R10", "done cleared by line start", int'(done_o), 0);
        check("R10", "sample with line start not merged", int'(pix_vld_o), 0);
        check("R10", "mean cleared by line start", int'(mean_o), 0);
        run_line(1, 1, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule